// File: doc/BRIEF.md
# Registered Command/Address Parity Front End

This block sits at the command and address edge of a registered DDR3-style memory module. On every rising clock edge it registers a row/column address, a bank address, the three active-low command strobes (row strobe, column strobe, write enable), a set of active-low chip selects and one parity bit supplied by the controller. The registered command and address drive the DRAM side one clock later. Parity is never allowed to hold back a DRAM command.

The registered bits, together with the parity bit, must contain an even number of ones. When the count is odd and at least one chip select is asserted, an active-low error flag is pulled low for a short, stretchable window. The block also holds a small bank of 4-bit configuration words. A dedicated command writes them. That write is dropped whenever its parity is wrong, so a corrupted transfer cannot change the configuration.

Top module: `ca_parity_front`

## Requirements
- R1: Inputs sampled at rising edge k appear unchanged on the DRAM-side outputs from edge k until edge k+1. Reset drives the forwarded chip selects all high and the forwarded strobes high.
- R2: A captured cycle fails parity when the count of ones is odd. The count covers the address (16 bits), the bank (3 bits), the row strobe, the column strobe, the write enable and the parity input.
- R3: A failing cycle captured at edge k drives err_n_o low at edge k+1. err_n_o stays low for two clock cycles and returns high at edge k+3 if no further failure occurs.
- R4: A further failure captured while err_n_o is low restarts the two-cycle window from that failure.
- R5: A cycle with every chip select high is a deselect. Parity is not checked for it, and it never pulls err_n_o low.
- R6: A DRAM command with failing parity is still forwarded exactly as captured.
- R7: A configuration write is every chip select low together with the row strobe, column strobe and write enable all low. It writes word index {bank[2], addr[4:3]} with the data {bank[1:0], addr[1:0]}. That word appears on cfg_o[4*index +: 4] from the second rising edge after the command is presented.
- R8: A configuration write with failing parity leaves every configuration word unchanged, and it still pulls err_n_o low.
- R9: When only some chip selects are low, a command with all three strobes low is an ordinary DRAM command. It does not write any configuration word, and its parity is still checked.
- R10: A synchronous active-high reset clears every configuration word to zero and releases err_n_o high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 16 | Address from the controller |
| bank_i | input | 3 | Bank address from the controller |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| cs_n_i | input | 2 | Chip selects, active low |
| par_i | input | 1 | Even-parity bit over address, bank and strobes |
| dram_addr_o | output | 16 | Registered address to the DRAMs |
| dram_bank_o | output | 3 | Registered bank address |
| dram_ras_n_o | output | 1 | Registered row strobe |
| dram_cas_n_o | output | 1 | Registered column strobe |
| dram_we_n_o | output | 1 | Registered write enable |
| dram_cs_n_o | output | 2 | Registered chip selects |
| err_n_o | output | 1 | Parity error flag, active low |
| cfg_o | output | 32 | Eight 4-bit configuration words, word i at bits 4*i+3:4*i |

## Verification
The bench targets the following cases:
- Back-to-back failures. A design that does not restart the window would release the flag too early.
- Odd parity on deselect cycles. A checker that ignores the chip selects would raise false errors.
- Configuration writes with bad parity. These catch a design that commits them anyway.
- Partial chip-select commands with all strobes low. These catch a design that decodes them as configuration writes.
- Every configuration index, which exposes swapped index or data bit fields.
- Forwarding of failing DRAM commands. A design that masks or drops them would show up as a mismatch against the cycle-by-cycle model.

// File: rtl/ca_pkg.sv
package ca_pkg;
   typedef enum logic [1:0] {
      CMD_IDLE = 2'd0,
      CMD_DRAM = 2'd1,
      CMD_CFGW = 2'd2
   } ca_kind_e;

   function automatic ca_kind_e ca_classify(input logic all_hi, input logic all_lo,
                                            input logic ras_n, input logic cas_n,
                                            input logic we_n);
      if (all_hi)
         return CMD_IDLE;
      if (all_lo && !ras_n && !cas_n && !we_n)
         return CMD_CFGW;
      return CMD_DRAM;
   endfunction
endpackage

// File: rtl/ca_capture_reg.sv
module ca_capture_reg #(
   parameter int ADDR_W = 16,
   parameter int BANK_W = 3,
   parameter int NCS    = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr_d,
   input  logic [BANK_W-1:0] bank_d,
   input  logic              ras_n_d,
   input  logic              cas_n_d,
   input  logic              we_n_d,
   input  logic [NCS-1:0]    cs_n_d,
   input  logic              par_d,
   output logic [ADDR_W-1:0] addr_q,
   output logic [BANK_W-1:0] bank_q,
   output logic              ras_n_q,
   output logic              cas_n_q,
   output logic              we_n_q,
   output logic [NCS-1:0]    cs_n_q,
   output logic              par_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q  <= '0;
         bank_q  <= '0;
         ras_n_q <= 1'b1;
         cas_n_q <= 1'b1;
         we_n_q  <= 1'b1;
         cs_n_q  <= '1;
         par_q   <= 1'b0;
      end else begin
         addr_q  <= addr_d;
         bank_q  <= bank_d;
         ras_n_q <= ras_n_d;
         cas_n_q <= cas_n_d;
         we_n_q  <= we_n_d;
         cs_n_q  <= cs_n_d;
         par_q   <= par_d;
      end
   end
endmodule

// File: rtl/ca_parity_check.sv
module ca_parity_check #(
   parameter int ADDR_W   = 16,
   parameter int BANK_W   = 3,
   parameter int ERR_HOLD = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              check_en,
   input  logic [ADDR_W-1:0] addr_q,
   input  logic [BANK_W-1:0] bank_q,
   input  logic              ras_n_q,
   input  logic              cas_n_q,
   input  logic              we_n_q,
   input  logic              par_q,
   output logic              fail,
   output logic              err_n
);
   localparam int CNT_W = (ERR_HOLD < 2) ? 1 : $clog2(ERR_HOLD + 1);

   logic odd_ones;
   assign odd_ones = ^{addr_q, bank_q, ras_n_q, cas_n_q, we_n_q, par_q};
   assign fail     = check_en & odd_ones;

   if (ERR_HOLD < 1) begin : g_bad_hold
      $error("ca_parity_check: ERR_HOLD must be at least 1");
   end

   if (ERR_HOLD == 1) begin : g_single
      logic err_q;
      always_ff @(posedge clk) begin
         if (rst) err_q <= 1'b0;
         else     err_q <= fail;
      end
      assign err_n = ~err_q;
   end else begin : g_stretch
      logic [CNT_W-1:0] left_q;
      always_ff @(posedge clk) begin
         if (rst)
            left_q <= '0;
         else if (fail)
            left_q <= CNT_W'(ERR_HOLD);
         else if (left_q != '0)
            left_q <= left_q - 1'b1;
      end
      assign err_n = (left_q == '0);
   end
endmodule

// File: rtl/ca_ctrl_words.sv
module ca_ctrl_words #(
   parameter int IDX_W  = 3,
   parameter int WORD_W = 4
) (
   input  logic                            clk,
   input  logic                            rst,
   input  logic                            wr_en,
   input  logic [IDX_W-1:0]                wr_idx,
   input  logic [WORD_W-1:0]               wr_data,
   output logic [(1<<IDX_W)*WORD_W-1:0]    words
);
   localparam int NWORD = 1 << IDX_W;

   for (genvar i = 0; i < NWORD; i++) begin : g_word
      logic [WORD_W-1:0] w_q;
      always_ff @(posedge clk) begin
         if (rst)
            w_q <= '0;
         else if (wr_en && (wr_idx == IDX_W'(i)))
            w_q <= wr_data;
      end
      assign words[i*WORD_W +: WORD_W] = w_q;
   end
endmodule

// File: rtl/ca_parity_front.sv
module ca_parity_front #(
   parameter int ADDR_W   = 16,
   parameter int BANK_W   = 3,
   parameter int NCS      = 2,
   parameter int ERR_HOLD = 2,
   parameter int CFG_IDX_W  = 3,
   parameter int CFG_WORD_W = 4
) (
   input  logic                                    clk,
   input  logic                                    rst,
   input  logic [ADDR_W-1:0]                       addr_i,
   input  logic [BANK_W-1:0]                       bank_i,
   input  logic                                    ras_n_i,
   input  logic                                    cas_n_i,
   input  logic                                    we_n_i,
   input  logic [NCS-1:0]                          cs_n_i,
   input  logic                                    par_i,
   output logic [ADDR_W-1:0]                       dram_addr_o,
   output logic [BANK_W-1:0]                       dram_bank_o,
   output logic                                    dram_ras_n_o,
   output logic                                    dram_cas_n_o,
   output logic                                    dram_we_n_o,
   output logic [NCS-1:0]                          dram_cs_n_o,
   output logic                                    err_n_o,
   output logic [(1<<CFG_IDX_W)*CFG_WORD_W-1:0]    cfg_o
);
   import ca_pkg::*;

   if (ADDR_W < 5) begin : g_bad_addr
      $error("ca_parity_front: ADDR_W must be at least 5");
   end
   if (BANK_W != 3) begin : g_bad_bank
      $error("ca_parity_front: BANK_W must be 3");
   end
   if (CFG_IDX_W != 3 || CFG_WORD_W != 4) begin : g_bad_cfg
      $error("ca_parity_front: configuration field layout is fixed at 8 x 4 bits");
   end
   if (NCS < 1) begin : g_bad_cs
      $error("ca_parity_front: NCS must be at least 1");
   end

   logic [ADDR_W-1:0] addr_q;
   logic [BANK_W-1:0] bank_q;
   logic              ras_n_q, cas_n_q, we_n_q, par_q;
   logic [NCS-1:0]    cs_n_q;

   ca_capture_reg #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .NCS(NCS)) u_cap (
      .clk(clk), .rst(rst),
      .addr_d(addr_i), .bank_d(bank_i), .ras_n_d(ras_n_i), .cas_n_d(cas_n_i),
      .we_n_d(we_n_i), .cs_n_d(cs_n_i), .par_d(par_i),
      .addr_q(addr_q), .bank_q(bank_q), .ras_n_q(ras_n_q), .cas_n_q(cas_n_q),
      .we_n_q(we_n_q), .cs_n_q(cs_n_q), .par_q(par_q)
   );

   ca_kind_e kind;
   assign kind = ca_classify(&cs_n_q, ~|cs_n_q, ras_n_q, cas_n_q, we_n_q);

   logic fail;
   ca_parity_check #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .ERR_HOLD(ERR_HOLD)) u_par (
      .clk(clk), .rst(rst), .check_en(kind != CMD_IDLE),
      .addr_q(addr_q), .bank_q(bank_q), .ras_n_q(ras_n_q), .cas_n_q(cas_n_q),
      .we_n_q(we_n_q), .par_q(par_q), .fail(fail), .err_n(err_n_o)
   );

   logic [CFG_IDX_W-1:0]  cw_idx;
   logic [CFG_WORD_W-1:0] cw_data;
   assign cw_idx  = {bank_q[2], addr_q[4:3]};
   assign cw_data = {bank_q[1:0], addr_q[1:0]};

   ca_ctrl_words #(.IDX_W(CFG_IDX_W), .WORD_W(CFG_WORD_W)) u_cw (
      .clk(clk), .rst(rst),
      .wr_en((kind == CMD_CFGW) && !fail),
      .wr_idx(cw_idx), .wr_data(cw_data), .words(cfg_o)
   );

   assign dram_addr_o  = addr_q;
   assign dram_bank_o  = bank_q;
   assign dram_ras_n_o = ras_n_q;
   assign dram_cas_n_o = cas_n_q;
   assign dram_we_n_o  = we_n_q;
   assign dram_cs_n_o  = cs_n_q;
endmodule

// File: rtl/ca_parity_front_chk.sv
module ca_parity_front_chk #(
   parameter int ADDR_W = 16,
   parameter int BANK_W = 3,
   parameter int NCS    = 2,
   parameter int CFG_W  = 32
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] addr_i,
   input logic [BANK_W-1:0] bank_i,
   input logic              ras_n_i,
   input logic              cas_n_i,
   input logic              we_n_i,
   input logic [NCS-1:0]    cs_n_i,
   input logic              par_i,
   input logic [ADDR_W-1:0] dram_addr_o,
   input logic [BANK_W-1:0] dram_bank_o,
   input logic              dram_ras_n_o,
   input logic              dram_cas_n_o,
   input logic              dram_we_n_o,
   input logic [NCS-1:0]    dram_cs_n_o,
   input logic              err_n_o,
   input logic [CFG_W-1:0]  cfg_o
);
   logic bad_in, cfgw_in;
   assign bad_in  = !(&cs_n_i) && (^{addr_i, bank_i, ras_n_i, cas_n_i, we_n_i, par_i});
   assign cfgw_in = (cs_n_i == '0) && !ras_n_i && !cas_n_i && !we_n_i;

   // R1, R6: one-clock forwarding regardless of parity
   p_forward_r1: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (dram_addr_o == $past(addr_i)) && (dram_bank_o == $past(bank_i)) &&
               (dram_cs_n_o == $past(cs_n_i)) && (dram_ras_n_o == $past(ras_n_i)) &&
               (dram_cas_n_o == $past(cas_n_i)) && (dram_we_n_o == $past(we_n_i)));

   // R3: failure flagged one clock after capture
   p_err_after_fail_r3: assert property (@(posedge clk) disable iff (rst)
      bad_in |=> ##1 !err_n_o);

   // R3: flag lasts at least two cycles
   p_err_width_r3: assert property (@(posedge clk) disable iff (rst)
      $fell(err_n_o) |=> !err_n_o);

   // R8: failing configuration write leaves words unchanged
   p_bad_cfg_kept_r8: assert property (@(posedge clk) disable iff (rst)
      (bad_in && cfgw_in) |=> ##1 $stable(cfg_o));

   // R10: reset state
   p_reset_state_r10: assert property (@(posedge clk)
      rst |=> (err_n_o && (&dram_cs_n_o) && (cfg_o == '0)));
endmodule

bind ca_parity_front ca_parity_front_chk #(
   .ADDR_W(ADDR_W), .BANK_W(BANK_W), .NCS(NCS),
   .CFG_W((1<<CFG_IDX_W)*CFG_WORD_W)
) u_chk (
   .clk(clk), .rst(rst), .addr_i(addr_i), .bank_i(bank_i), .ras_n_i(ras_n_i),
   .cas_n_i(cas_n_i), .we_n_i(we_n_i), .cs_n_i(cs_n_i), .par_i(par_i),
   .dram_addr_o(dram_addr_o), .dram_bank_o(dram_bank_o),
   .dram_ras_n_o(dram_ras_n_o), .dram_cas_n_o(dram_cas_n_o),
   .dram_we_n_o(dram_we_n_o), .dram_cs_n_o(dram_cs_n_o),
   .err_n_o(err_n_o), .cfg_o(cfg_o)
);

// File: tb/tb_ca_parity_front.sv
`timescale 1ns/1ps
module tb_ca_parity_front;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] addr_i = '0;
   logic [2:0]  bank_i = '0;
   logic        ras_n_i = 1'b1, cas_n_i = 1'b1, we_n_i = 1'b1;
   logic [1:0]  cs_n_i = 2'b11;
   logic        par_i = 1'b0;
   logic [15:0] dram_addr_o;
   logic [2:0]  dram_bank_o;
   logic        dram_ras_n_o, dram_cas_n_o, dram_we_n_o;
   logic [1:0]  dram_cs_n_o;
   logic        err_n_o;
   logic [31:0] cfg_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   string cur_req = "R10";

   always #10 clk = ~clk;

   ca_parity_front dut (
      .clk(clk), .rst(rst), .addr_i(addr_i), .bank_i(bank_i), .ras_n_i(ras_n_i),
      .cas_n_i(cas_n_i), .we_n_i(we_n_i), .cs_n_i(cs_n_i), .par_i(par_i),
      .dram_addr_o(dram_addr_o), .dram_bank_o(dram_bank_o),
      .dram_ras_n_o(dram_ras_n_o), .dram_cas_n_o(dram_cas_n_o),
      .dram_we_n_o(dram_we_n_o), .dram_cs_n_o(dram_cs_n_o),
      .err_n_o(err_n_o), .cfg_o(cfg_o)
   );

   // behavioural reference model
   logic [25:0] m_fwd;      // {addr, bank, ras, cas, we, cs}
   int          m_win;
   logic [3:0]  m_cfg [8];
   bit          p_chk, p_bad, p_wr;
   int          p_idx;
   logic [3:0]  p_dat;

   always @(posedge clk) begin
      if (rst) begin
         m_fwd = {16'h0, 3'h0, 1'b1, 1'b1, 1'b1, 2'b11};
         m_win = 0;
         foreach (m_cfg[i]) m_cfg[i] = 4'h0;
         p_chk = 0; p_bad = 0; p_wr = 0; p_idx = 0; p_dat = 0;
      end else begin
         if (p_chk && p_bad) m_win = 2;
         else if (m_win > 0) m_win = m_win - 1;
         if (p_wr && !p_bad) m_cfg[p_idx] = p_dat;
         m_fwd = {addr_i, bank_i, ras_n_i, cas_n_i, we_n_i, cs_n_i};
         p_chk = (cs_n_i != 2'b11);
         p_bad = p_chk && ($countones({addr_i, bank_i, ras_n_i, cas_n_i, we_n_i, par_i}) % 2 == 1);
         p_wr  = (cs_n_i == 2'b00) && !ras_n_i && !cas_n_i && !we_n_i;
         p_idx = int'({bank_i[2], addr_i[4:3]});
         p_dat = {bank_i[1:0], addr_i[1:0]};
      end
   end

   task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
      end
   endtask

   task automatic compare();
      logic [31:0] ecfg;
      for (int i = 0; i < 8; i++) ecfg[i*4 +: 4] = m_cfg[i];
      check("forward", 32'({dram_addr_o, dram_bank_o, dram_ras_n_o, dram_cas_n_o,
                            dram_we_n_o, dram_cs_n_o}), 32'(m_fwd));
      check("err_n", 32'(err_n_o), 32'(m_win == 0));
      check("cfg", cfg_o, ecfg);
   endtask

   // one cycle: compare at the falling edge, then drive the next inputs
   task automatic step(input logic [15:0] a, input logic [2:0] b, input logic [2:0] cmd_n,
                       input logic [1:0] cs, input bit bad);
      @(negedge clk);
      compare();
      addr_i = a; bank_i = b;
      {ras_n_i, cas_n_i, we_n_i} = cmd_n;
      cs_n_i = cs;
      par_i = (^{a, b, cmd_n}) ^ bad;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(16'h0, 3'h0, 3'b111, 2'b11, 0);
   endtask

   task automatic cfg_write(input int idx, input logic [3:0] d, input bit bad);
      logic [15:0] a;
      logic [2:0] b;
      a = 16'hA5E4 & ~16'h001B;
      a[4:3] = idx[1:0];
      a[1:0] = d[1:0];
      b = {idx[2], d[3:2]};
      step(a, b, 3'b000, 2'b00, bad);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      cur_req = "R10";
      check("reset err_n", 32'(err_n_o), 32'd1);
      check("reset cs", 32'(dram_cs_n_o), 32'h3);
      check("reset cfg", cfg_o, 32'h0);
      rst = 1'b0;

      cur_req = "R1";
      for (int i = 0; i < 20; i++)
         step(16'(i * 4093 + 7), 3'(i), 3'(i % 7), 2'(i % 3), 0);
      idle(3);

      cur_req = "R2";
      step(16'h0001, 3'h0, 3'b111, 2'b10, 0);
      step(16'h8000, 3'h4, 3'b011, 2'b01, 1);
      idle(4);

      cur_req = "R3";
      step(16'h1234, 3'h2, 3'b101, 2'b10, 1);
      idle(5);

      cur_req = "R4";
      step(16'h0F0F, 3'h1, 3'b110, 2'b01, 1);
      idle(1);
      step(16'h0F0E, 3'h1, 3'b110, 2'b01, 1);
      idle(5);

      cur_req = "R5";
      for (int i = 0; i < 6; i++) step(16'(i * 77), 3'(i), 3'(i), 2'b11, 1);
      idle(3);

      cur_req = "R6";
      step(16'hBEEF, 3'h6, 3'b001, 2'b00, 1);
      step(16'hCAFE, 3'h3, 3'b100, 2'b10, 1);
      idle(4);

      cur_req = "R7";
      for (int i = 0; i < 8; i++) cfg_write(i, 4'(i * 5 + 3), 0);
      idle(3);

      cur_req = "R8";
      cfg_write(2, 4'h9, 1);
      idle(3);
      cfg_write(7, 4'h1, 1);
      cfg_write(5, 4'hE, 0);
      idle(4);

      cur_req = "R9";
      step(16'h0018, 3'h7, 3'b000, 2'b01, 0);
      step(16'h0008, 3'h3, 3'b000, 2'b10, 1);
      idle(4);

      cur_req = "R10";
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check("reset err_n", 32'(err_n_o), 32'd1);
      check("reset cfg", cfg_o, 32'h0);
      check("reset cs", 32'(dram_cs_n_o), 32'h3);
      rst = 1'b0;
      idle(3);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule